// File: doc/BRIEF.md
# Quarter-Duty Multiplexed LCD Waveform Generator

This block turns an 88-bit display image into drive-level codes for a multiplexed LCD with four common electrodes and twenty-two segment electrodes. It does not produce voltages. Each pin gets a 2-bit code that selects one tap of an external bias ladder: code 0 is ground, code 1 is the lower middle tap, code 2 is the upper middle tap and code 3 is the full drive rail.

Timing comes from an oscillator tick input. A frame lasts 512 ticks and is split into four equal phases of 128 ticks. Each phase selects one common. Every code is complemented in alternate frames, so the panel sees no net DC. A run-time bit chooses between third-bias and half-bias drive. Three separate paths force the output off:

- a segments-blank bit, which leaves the commons running;
- a power-save bit, which stops the sequencer;
- an active-low inhibit input, which forces every pin to ground but lets the timing run on.

The sequencer is a five-state machine:

- `ST_COM1`, `ST_COM2`, `ST_COM3` and `ST_COM4` each select one common.
- `ST_HALT` is the power-save state.

Its transitions are:

- **phase step**: on the 128th tick of a phase, the machine moves from `ST_COMk` to `ST_COMk+1`.
- **frame wrap**: on the 128th tick of `ST_COM4`, it moves to `ST_COM1` and the polarity toggles.
- **sleep**: from any phase state, a high `pwr_save` moves it to `ST_HALT`.
- **wake**: from `ST_HALT`, a low `pwr_save` moves it to `ST_COM1`.

Top module: `lcdw_top`

## Requirements
- R1: After reset the sequencer is in `ST_COM1` with positive polarity and its tick count at zero. With `inhibit_n`=1, `pwr_save`=0 and third bias, `com_lvl[1:0]` is 3, the other commons are 1, and segments follow the image for common 1.
- R2: The display bit for segment s (0..21) and common c (0..3) is `disp_img[4*s+c]`. Segment s drives `seg_lvl[2*s+:2]` and common c drives `com_lvl[2*c+:2]`. A bit value of 1 means the segment is on.
- R3: Only clock cycles with `tick`=1 count. After 128 counted ticks the phase moves to the next common. Four phases make one 512-tick frame, after which common 1 is selected again.
- R4: In a positive frame with third bias, the selected common drives 3 and the unselected commons drive 1. An on segment drives 0 and an off segment drives 2.
- R5: In a negative frame every code is replaced by 3 minus the positive-frame code. The polarity toggles each time the sequencer wraps from common 4 back to common 1.
- R6: With `bias_half`=1, both middle codes (1 and 2) are emitted as 1. Codes 0 and 3 are unchanged. No pin ever shows code 2.
- R7: With `seg_blank`=1, every segment drives its off-segment code whatever the image holds. The commons are unaffected.
- R8: While `pwr_save`=1, every pin drives 0. From the next cycle the machine sits in `ST_HALT` with its count and polarity cleared. Power-save takes priority over a phase-ending tick in the same cycle. After release, the machine restarts at common 1, positive polarity, count zero.
- R9: While `inhibit_n`=0, every pin drives 0 whatever the control bits hold. Tick counting and phase stepping continue unchanged during inhibit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle oscillator tick |
| disp_img | input | 88 | Display image, bit 4*s+c for segment s and common c |
| bias_half | input | 1 | 1 selects half bias, 0 selects third bias |
| seg_blank | input | 1 | Forces segments to the off waveform |
| pwr_save | input | 1 | Stops timing and grounds all pins |
| inhibit_n | input | 1 | Active-low display inhibit |
| com_lvl | output | 8 | Common level codes, 2 bits per common |
| seg_lvl | output | 44 | Segment level codes, 2 bits per segment |

## Verification
The frame-wrap transition and the sleep transition can land in the same clock edge. This happens when `pwr_save` rises together with the final tick of common 4. The bench provokes exactly that edge, then releases power-save and checks that the outputs show common 1 in positive polarity rather than a flipped frame. It also checks that a further 127 ticks leave the phase unchanged, which shows the count restarted from zero. A second overlap is inhibit spanning a phase boundary: the bench counts ticks through the inhibit window and then checks that the phase stepped forward underneath it.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

    localparam int N_COM = 4;

    typedef enum logic [1:0] {
        LV_GND   = 2'd0,
        LV_LOMID = 2'd1,
        LV_HIMID = 2'd2,
        LV_FULL  = 2'd3
    } lvl_t;

    typedef enum logic [2:0] {
        ST_COM1 = 3'd0,
        ST_COM2 = 3'd1,
        ST_COM3 = 3'd2,
        ST_COM4 = 3'd3,
        ST_HALT = 3'd4
    } seq_st_t;

    // Apply frame polarity and bias folding to a positive-frame code.
    function automatic logic [1:0] shape_lvl(input logic [1:0] raw,
                                             input logic       neg,
                                             input logic       half);
        logic [1:0] v;
        v = neg ? ~raw : raw;
        if (half && (v == LV_LOMID || v == LV_HIMID))
            v = LV_LOMID;
        return v;
    endfunction

endpackage

// File: rtl/lcdw_seq.sv
module lcdw_seq #(
    parameter int FRAME_TICKS = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       pwr_save,
    output logic [1:0] phase,
    output logic       neg,
    output logic       halted
);
    import lcdw_pkg::*;

    localparam int PHASE_TICKS = FRAME_TICKS / N_COM;
    localparam int CW          = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1;

    seq_st_t       st, st_nx;
    logic [CW-1:0] cnt;
    logic          last;

    assign last = (cnt == CW'(PHASE_TICKS - 1));

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_COM1: st_nx = pwr_save ? ST_HALT : ((tick && last) ? ST_COM2 : ST_COM1);
            ST_COM2: st_nx = pwr_save ? ST_HALT : ((tick && last) ? ST_COM3 : ST_COM2);
            ST_COM3: st_nx = pwr_save ? ST_HALT : ((tick && last) ? ST_COM4 : ST_COM3);
            ST_COM4: st_nx = pwr_save ? ST_HALT : ((tick && last) ? ST_COM1 : ST_COM4);
            ST_HALT: st_nx = pwr_save ? ST_HALT : ST_COM1;
            default: st_nx = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_COM1;
            cnt <= '0;
            neg <= 1'b0;
        end else begin
            st <= st_nx;
            if (pwr_save || st == ST_HALT) begin
                cnt <= '0;
                neg <= 1'b0;
            end else if (tick) begin
                cnt <= last ? '0 : cnt + 1'b1;
                if (last && st == ST_COM4)
                    neg <= ~neg;
            end
        end
    end

    always_comb begin
        halted = 1'b0;
        phase  = 2'd0;
        unique case (st)
            ST_COM1: phase = 2'd0;
            ST_COM2: phase = 2'd1;
            ST_COM3: phase = 2'd2;
            ST_COM4: phase = 2'd3;
            ST_HALT: halted = 1'b1;
            default: halted = 1'b1;
        endcase
    end

    // R3
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_HALT && $past(st) != ST_HALT && st != $past(st)) |-> $past(tick));

    // R8
    halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_save |=> (st == ST_HALT && cnt == '0 && !neg));

    // R5
    frame_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COM1 && $past(st) == ST_COM4) |-> (neg != $past(neg)));

endmodule

// File: rtl/lcdw_com_drv.sv
module lcdw_com_drv (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] phase,
    input  logic       neg,
    input  logic       half,
    input  logic       force_off,
    output logic [7:0] com_lvl
);
    import lcdw_pkg::*;

    logic [N_COM-1:0] on_rail;

    for (genvar c = 0; c < N_COM; c++) begin : g_com
        logic [1:0] raw;
        assign raw = (phase == 2'(c)) ? LV_FULL : LV_LOMID;
        assign com_lvl[2*c +: 2] = force_off ? LV_GND : shape_lvl(raw, neg, half);
        assign on_rail[c] = (com_lvl[2*c +: 2] == LV_GND) || (com_lvl[2*c +: 2] == LV_FULL);
    end

    // R4
    one_rail_com_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !force_off |-> ($countones(on_rail) == 1));

endmodule

// File: rtl/lcdw_seg_drv.sv
module lcdw_seg_drv #(
    parameter int N_SEG = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [4*N_SEG-1:0] img,
    input  logic [1:0]         phase,
    input  logic               neg,
    input  logic               half,
    input  logic               blank,
    input  logic               force_off,
    output logic [2*N_SEG-1:0] seg_lvl
);
    import lcdw_pkg::*;

    logic [N_SEG-1:0] on_rail;

    for (genvar s = 0; s < N_SEG; s++) begin : g_seg
        logic [3:0] nib;
        logic       lit;
        logic [1:0] raw;
        assign nib = img[4*s +: 4];
        assign lit = nib[phase] && !blank;
        assign raw = lit ? LV_GND : LV_HIMID;
        assign seg_lvl[2*s +: 2] = force_off ? LV_GND : shape_lvl(raw, neg, half);
        assign on_rail[s] = (seg_lvl[2*s +: 2] == LV_GND) || (seg_lvl[2*s +: 2] == LV_FULL);
    end

    // R7
    blank_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && !force_off) |-> (on_rail == '0));

endmodule

// File: rtl/lcdw_top.sv
module lcdw_top #(
    parameter int N_SEG       = 22,
    parameter int FRAME_TICKS = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [4*N_SEG-1:0] disp_img,
    input  logic               bias_half,
    input  logic               seg_blank,
    input  logic               pwr_save,
    input  logic               inhibit_n,
    output logic [7:0]         com_lvl,
    output logic [2*N_SEG-1:0] seg_lvl
);
    import lcdw_pkg::*;

    logic [1:0] phase;
    logic       neg;
    logic       halted;
    logic       force_off;

    assign force_off = !inhibit_n || pwr_save || halted;

    lcdw_seq #(.FRAME_TICKS(FRAME_TICKS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .pwr_save (pwr_save),
        .phase    (phase),
        .neg      (neg),
        .halted   (halted)
    );

    lcdw_com_drv u_com (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .neg       (neg),
        .half      (bias_half),
        .force_off (force_off),
        .com_lvl   (com_lvl)
    );

    lcdw_seg_drv #(.N_SEG(N_SEG)) u_seg (
        .clk       (clk),
        .rst_n     (rst_n),
        .img       (disp_img),
        .phase     (phase),
        .neg       (neg),
        .half      (bias_half),
        .blank     (seg_blank),
        .force_off (force_off),
        .seg_lvl   (seg_lvl)
    );

    logic [N_COM+N_SEG-1:0] is_hi_mid;
    for (genvar i = 0; i < N_COM; i++) begin : g_hc
        assign is_hi_mid[i] = (com_lvl[2*i +: 2] == LV_HIMID);
    end
    for (genvar i = 0; i < N_SEG; i++) begin : g_hs
        assign is_hi_mid[N_COM+i] = (seg_lvl[2*i +: 2] == LV_HIMID);
    end

    // R9
    inhibit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit_n |-> (com_lvl == '0 && seg_lvl == '0));

    // R8
    save_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_save |-> (com_lvl == '0 && seg_lvl == '0));

    // R6
    half_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bias_half |-> (is_hi_mid == '0));

endmodule

// File: tb/lcdw_top_tb_top.sv
module lcdw_top_tb_top;

    localparam int NS = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [4*NS-1:0] disp_img = '0;
    logic          bias_half = 1'b0;
    logic          seg_blank = 1'b0;
    logic          pwr_save = 1'b0;
    logic          inhibit_n = 1'b1;
    logic [7:0]    com_lvl;
    logic [2*NS-1:0] seg_lvl;

    int n_tests = 0;
    int n_fail  = 0;
    int tb_ticks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lcdw_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .disp_img(disp_img),
        .bias_half(bias_half), .seg_blank(seg_blank), .pwr_save(pwr_save),
        .inhibit_n(inhibit_n), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    function automatic logic [1:0] fold(input logic [1:0] pos, input bit pol, input bit half);
        logic [1:0] v;
        v = pol ? 2'(3 - pos) : pos;
        if (half && (v == 2'd1 || v == 2'd2)) v = 2'd1;
        return v;
    endfunction

    task automatic check_all(input string req, input bit forced);
        int  ph;
        bit  pol;
        bit  bad;
        logic [1:0] e, a;
        ph  = (tb_ticks % 512) / 128;
        pol = ((tb_ticks / 512) % 2) == 1;
        bad = 0;
        n_tests++;
        for (int c = 0; c < 4; c++) begin
            e = forced ? 2'd0 : fold((c == ph) ? 2'd3 : 2'd1, pol, bias_half);
            a = com_lvl[2*c +: 2];
            if (!bad && a !== e) begin
                $display("FAIL %s com%0d actual=%0d expected=%0d", req, c, a, e);
                bad = 1;
            end
        end
        for (int s = 0; s < NS; s++) begin
            e = forced ? 2'd0 :
                fold((disp_img[4*s+ph] && !seg_blank) ? 2'd0 : 2'd2, pol, bias_half);
            a = seg_lvl[2*s +: 2];
            if (!bad && a !== e) begin
                $display("FAIL %s seg%0d actual=%0d expected=%0d", req, s, a, e);
                bad = 1;
            end
        end
        if (bad) n_fail++;
    endtask

    task automatic give_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            tb_ticks++;
        end
    endtask

    task automatic t_reset;
        disp_img = '0;
        disp_img[0] = 1'b1;
        disp_img[4*21] = 1'b1;
        @(negedge clk);
        check_all("R1 reset", 0);
    endtask

    task automatic t_map_phase;
        disp_img = '0;
        disp_img[40] = 1'b1;
        disp_img[4*3+2] = 1'b1;
        disp_img[4*20+3] = 1'b1;
        @(negedge clk);
        check_all("R2 R4 map", 0);
        give_ticks(127);
        check_all("R3 phase hold", 0);
        give_ticks(1);
        check_all("R3 phase step", 0);
        give_ticks(128);
        check_all("R2 R3 common3", 0);
        give_ticks(128);
        check_all("R2 R3 common4", 0);
    endtask

    task automatic t_polarity;
        give_ticks(128);
        check_all("R5 negative frame", 0);
        give_ticks(128 + 50);
        check_all("R5 negative common2", 0);
        give_ticks(512 - 178);
        check_all("R5 back positive", 0);
    endtask

    task automatic t_half;
        bias_half = 1'b1;
        disp_img = {22{4'b1010}};
        @(negedge clk);
        check_all("R6 half positive", 0);
        give_ticks(512);
        check_all("R6 half negative", 0);
        bias_half = 1'b0;
    endtask

    task automatic t_blank;
        seg_blank = 1'b1;
        disp_img = '1;
        @(negedge clk);
        check_all("R7 blank", 0);
        give_ticks(128);
        check_all("R7 blank step", 0);
        seg_blank = 1'b0;
    endtask

    task automatic t_inhibit;
        bias_half = 1'b0;
        disp_img = {22{4'b0110}};
        inhibit_n = 1'b0;
        @(negedge clk);
        check_all("R9 inhibit off", 1);
        give_ticks(128);
        check_all("R9 inhibit held", 1);
        inhibit_n = 1'b1;
        @(negedge clk);
        check_all("R9 timing ran", 0);
    endtask

    task automatic t_save_collide;
        int need;
        need = 511 - (tb_ticks % 512);
        give_ticks(need);
        check_all("R8 pre-collision", 0);
        @(negedge clk) begin tick = 1'b1; pwr_save = 1'b1; end
        @(negedge clk) tick = 1'b0;
        check_all("R8 save off", 1);
        give_ticks(5);
        check_all("R8 save held", 1);
        pwr_save = 1'b0;
        tb_ticks = 0;
        @(negedge clk);
        @(negedge clk);
        check_all("R8 restart", 0);
        give_ticks(127);
        check_all("R8 count cleared", 0);
        give_ticks(1);
        check_all("R8 R3 first step", 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map_phase();
        t_polarity();
        t_half();
        t_blank();
        t_inhibit();
        t_save_collide();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule